// File: doc/BRIEF.md
# Oversampling Serial Frame Receiver

This block turns the asynchronous serial input line into bytes. A shared rate generator supplies a one-clock tick at sixteen times the bit rate. The receiver resynchronises the line, finds the falling edge of a start bit and confirms it half a bit later. It then samples each following bit at its centre: the data bits, an optional parity bit and one stop bit. The frame layout comes from the same word-length and parity settings that the transmitter uses.

At the end of each frame the assembled byte is presented together with a one-clock done strobe, which the surrounding logic uses as the write strobe of a receive FIFO. A bad parity bit and a low stop bit each produce their own one-clock error pulse. The receiver does not start a new frame while it is halted or while the receive FIFO reports full. The FIFO storage, the register file and the rate generator are outside this block.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset `rxDone`, `parityErr` and `stopErr` are 0 and `rxByte` is 0x00. The synchronised line is taken as high (idle).
- R2: `rxLine` passes through two flops before any use. A falling edge starts a count of 8 ticks, and at the eighth tick the start bit is accepted only if the line is still low. A shorter low pulse is rejected and produces no frame.
- R3: A falling edge starts nothing while `rxHold` is 1 or `fifoFull` is 1. The receiver stays idle and no strobe follows from that edge.
- R4: Data bits are received least significant bit first. The bit count comes from `wordSel`: 00 gives 8 bits, 01 gives 7, 10 gives 6 and 11 gives 5. Shorter words appear right-aligned in `rxByte` with the unused upper bits at 0.
- R5: `parSel` 00 selects even parity and 01 selects odd parity. Either 1x value means the frame has no parity bit. When parity is on, the parity bit is the bit right after the last data bit.
- R6: When the sampled parity bit does not match the selected parity of the received data bits, `parityErr` is high for exactly one clock.
- R7: The stop bit is sampled after the data bits, or after the parity bit when there is one. If it is low, `stopErr` is high for one clock together with `rxDone`. The receiver returns to idle in either case and accepts the next start bit.
- R8: Each bit after the start bit is sampled 16 ticks after the previous sample. `rxDone` is a one-clock pulse in the clock after the stop-bit sample, and `rxByte` holds the frame's data in that clock and until the next frame ends.
- R9: `parityErr` never coincides with `rxDone`, because the parity pulse precedes the stop-bit sample by a full bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-clock pulse at 16 times the bit rate |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| rxHold | input | 1 | 1 halts the receiver before a new frame starts |
| fifoFull | input | 1 | Receive FIFO has no free entry |
| wordSel | input | 2 | Word length: 00=8, 01=7, 10=6, 11=5 bits |
| parSel | input | 2 | Parity: 00 even, 01 odd, 1x none |
| rxByte | output | 8 | Received data, right-aligned |
| rxDone | output | 1 | One-clock strobe: frame complete, push `rxByte` |
| parityErr | output | 1 | One-clock strobe: parity mismatch |
| stopErr | output | 1 | One-clock strobe: stop bit was low |

## Verification
The assertions check on every cycle that the done and parity-error strobes last one clock and that a stop error arrives only with a done strobe. They also check that parity errors never share a clock with done, that a halted idle receiver does not arm on an edge, that frame states advance only on ticks, and that 5-bit words keep zero upper bits. Correct bit ordering, the word lengths, the parity polarity, the rejection of glitches and the refusal on a full FIFO depend on whole frames. Only the bench's scenarios show these, by comparing every clock against a behavioural model and checking each captured byte.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_SHIFT  = 2'd1,
    RX_PARITY = 2'd2,
    RX_STOP   = 2'd3
  } rxState_t;

  typedef struct packed {
    logic             clearData;
    logic             sampleData;
    logic [IDX_W-1:0] bitIdx;
    logic             checkParity;
    logic             parOdd;
    logic             checkStop;
  } rxStrobe_t;
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       rxHold,
  input  logic       fifoFull,
  input  logic [1:0] wordSel,
  input  logic [1:0] parSel,
  input  logic       lineNow,
  input  logic       lineFell,
  output rxStrobe_t  strobe
);
  localparam int CNT_W = $clog2(TICKS_PER_BIT);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TICKS_PER_BIT - 1);

  rxState_t         state;
  logic             pending;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             parEn;
  logic             bitDue;
  logic             startDue;

  assign lastIdx  = IDX_W'(7) - IDX_W'(wordSel);
  assign parEn    = ~parSel[1];
  assign bitDue   = tick16 && (tickCnt == LAST_CNT);
  assign startDue = tick16 && (tickCnt == MID_CNT);

  always_comb begin
    strobe             = '0;
    strobe.bitIdx      = bitIdx;
    strobe.parOdd      = parSel[0];
    strobe.clearData   = (state == RX_IDLE) && pending && startDue && !lineNow;
    strobe.sampleData  = (state == RX_SHIFT) && bitDue;
    strobe.checkParity = (state == RX_PARITY) && bitDue;
    strobe.checkStop   = (state == RX_STOP) && bitDue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      pending <= 1'b0;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      case (state)
        RX_IDLE: begin
          if (!pending) begin
            if (lineFell && !rxHold && !fifoFull) begin
              pending <= 1'b1;
              tickCnt <= '0;
            end
          end else if (startDue) begin
            pending <= 1'b0;
            tickCnt <= '0;
            if (!lineNow) begin
              state  <= RX_SHIFT;
              bitIdx <= '0;
            end
          end else if (tick16) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_SHIFT: begin
          if (bitDue) begin
            tickCnt <= '0;
            if (bitIdx == lastIdx) state <= parEn ? RX_PARITY : RX_STOP;
            else                   bitIdx <= bitIdx + 1'b1;
          end else if (tick16) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_PARITY: begin
          if (bitDue) begin
            tickCnt <= '0;
            state   <= RX_STOP;
          end else if (tick16) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: begin
          if (bitDue) begin
            tickCnt <= '0;
            state   <= RX_IDLE;
          end else if (tick16) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
      endcase
    end
  end

  // A halted, unarmed receiver stays unarmed (R3)
  assert_hold_keeps_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_IDLE && !pending && rxHold) |=> (state == RX_IDLE && !pending));

  // Frame states advance only on a tick (R8)
  assert_advance_on_tick_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state != RX_IDLE && !tick16) |=> $stable(state));
endmodule

// File: rtl/uart_rx_dpath.sv
module uart_rx_dpath
  import uart_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  rxStrobe_t         strobe,
  output logic              lineNow,
  output logic              lineFell,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxDone,
  output logic              parityErr,
  output logic              stopErr
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevLine;
  logic [DATA_W-1:0]      dataQ;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= 1'b1;
        else if (s == 0) syncQ[s] <= rxLine;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign lineNow  = syncQ[SYNC_STAGES-1];
  assign lineFell = prevLine & ~lineNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLine  <= 1'b1;
      dataQ     <= '0;
      rxByte    <= '0;
      rxDone    <= 1'b0;
      parityErr <= 1'b0;
      stopErr   <= 1'b0;
    end else begin
      prevLine  <= lineNow;
      rxDone    <= strobe.checkStop;
      stopErr   <= strobe.checkStop & ~lineNow;
      parityErr <= strobe.checkParity & ((^dataQ) ^ lineNow ^ strobe.parOdd);
      if (strobe.clearData) dataQ <= '0;
      else if (strobe.sampleData) dataQ[strobe.bitIdx] <= lineNow;
      if (strobe.checkStop) rxByte <= dataQ;
    end
  end

  assert_done_one_clock_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);

  assert_parity_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |=> !parityErr);

  assert_stop_err_with_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    stopErr |-> rxDone);

  assert_parity_apart_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(parityErr && rxDone));
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       rxLine,
  input  logic       rxHold,
  input  logic       fifoFull,
  input  logic [1:0] wordSel,
  input  logic [1:0] parSel,
  output logic [7:0] rxByte,
  output logic       rxDone,
  output logic       parityErr,
  output logic       stopErr
);
  rxStrobe_t strobe;
  logic      lineNow;
  logic      lineFell;

  uart_rx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxHold(rxHold),
    .fifoFull(fifoFull), .wordSel(wordSel), .parSel(parSel),
    .lineNow(lineNow), .lineFell(lineFell), .strobe(strobe)
  );

  uart_rx_dpath #(.SYNC_STAGES(SYNC_STAGES), .DATA_W(8)) dpath_i (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .strobe(strobe),
    .lineNow(lineNow), .lineFell(lineFell), .rxByte(rxByte),
    .rxDone(rxDone), .parityErr(parityErr), .stopErr(stopErr)
  );

  // Five-bit words leave the upper three bits clear (R4)
  assert_short_word_aligned_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && $past(wordSel) == 2'b11 && $stable(wordSel)) |-> (rxByte[7:5] == 3'b000));
endmodule

// File: tb/uart_frame_rx_tb.sv
module uart_frame_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = TICK_DIV * 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0;
  logic rxLine = 1'b1;
  logic rxHold = 1'b0;
  logic fifoFull = 1'b0;
  logic [1:0] wordSel = 2'b00;
  logic [1:0] parSel = 2'b10;
  logic [7:0] rxByte;
  logic rxDone, parityErr, stopErr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int doneSeen = 0, perrSeen = 0, serrSeen = 0;
  logic [7:0] lastByte = 8'h00;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_rx dut_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxLine(rxLine), .rxHold(rxHold),
    .fifoFull(fifoFull), .wordSel(wordSel), .parSel(parSel), .rxByte(rxByte),
    .rxDone(rxDone), .parityErr(parityErr), .stopErr(stopErr)
  );

  // tick generator
  int tickDiv = 0;
  always @(negedge clk) begin
    tickDiv = (tickDiv + 1) % TICK_DIV;
    tick16 <= (tickDiv == 0);
  end

  // behavioural reference model
  int mState = 0;            // 0 idle, 1 data, 2 parity, 3 stop
  bit mPend = 0;
  int mCnt = 0, mIdx = 0;
  bit mS1 = 1, mS2 = 1, mPrev = 1;
  logic [7:0] mData = 0, mByte = 0;
  bit mDone = 0, mPerr = 0, mSerr = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mPend = 0; mCnt = 0; mIdx = 0;
      mS1 = 1; mS2 = 1; mPrev = 1; mData = 0; mByte = 0;
      mDone = 0; mPerr = 0; mSerr = 0;
    end else begin
      automatic int nBits = 8 - int'(wordSel);
      automatic bit hasPar = !parSel[1];
      mDone = 0; mPerr = 0; mSerr = 0;
      if (mState == 0) begin
        if (!mPend) begin
          if (mPrev && !mS2 && !rxHold && !fifoFull) begin mPend = 1; mCnt = 0; end
        end else if (tick16) begin
          if (mCnt == 7) begin
            mPend = 0; mCnt = 0;
            if (!mS2) begin mState = 1; mIdx = 0; mData = 0; end
          end else mCnt++;
        end
      end else if (tick16) begin
        if (mCnt == 15) begin
          mCnt = 0;
          if (mState == 1) begin
            mData[mIdx] = mS2;
            if (mIdx == nBits - 1) mState = hasPar ? 2 : 3;
            else mIdx++;
          end else if (mState == 2) begin
            mPerr = (^mData) ^ mS2 ^ parSel[0];
            mState = 3;
          end else begin
            mDone = 1; mSerr = !mS2; mByte = mData; mState = 0;
          end
        end else mCnt++;
      end
      mPrev = mS2; mS2 = mS1; mS1 = rxLine;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison and event capture
  always @(negedge clk) begin
    if (rstN && !finished) begin
      cycles++;
      check(rxDone == mDone, "R8", "rxDone vs model", rxDone, mDone);
      check(parityErr == mPerr, "R6", "parityErr vs model", parityErr, mPerr);
      check(stopErr == mSerr, "R7", "stopErr vs model", stopErr, mSerr);
      if (mDone) check(rxByte == mByte, "R4", "rxByte vs model", rxByte, mByte);
      if (rxDone) begin doneSeen++; lastByte = rxByte; end
      if (parityErr) perrSeen++;
      if (stopErr) serrSeen++;
    end
  end

  task automatic waitClks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic driveBit(input bit b, input int clks);
    rxLine = b;
    waitClks(clks);
  endtask

  // frame: start, data LSB first, optional parity (flip forces error), stop
  task automatic sendFrame(input logic [7:0] d, input int nBits, input int par,
                           input bit flipPar, input bit stopVal);
    driveBit(1'b0, BIT_CLKS);
    for (int i = 0; i < nBits; i++) driveBit(d[i], BIT_CLKS);
    if (par != 2) begin
      automatic bit p = 1'b0;
      for (int i = 0; i < nBits; i++) p ^= d[i];
      p ^= par[0];
      driveBit(p ^ flipPar, BIT_CLKS);
    end
    driveBit(stopVal, BIT_CLKS);
    driveBit(1'b1, 3 * BIT_CLKS);
  endtask

  task automatic clearCounts();
    doneSeen = 0; perrSeen = 0; serrSeen = 0;
  endtask

  task automatic frameCase(input logic [7:0] d, input logic [1:0] ws, input logic [1:0] ps,
                           input bit flipPar, input bit stopVal, input string req);
    automatic int n = 8 - int'(ws);
    automatic logic [7:0] expByte = d & ((8'h01 << n) - 8'h01);
    wordSel = ws; parSel = ps;
    clearCounts();
    sendFrame(d, n, int'(ps), flipPar, stopVal);
    check(doneSeen == 1, req, "one done per frame", doneSeen, 1);
    check(lastByte == expByte, req, "received byte", lastByte, expByte);
    check(perrSeen == int'(flipPar && !ps[1]), req, "parity error count",
          perrSeen, int'(flipPar && !ps[1]));
    check(serrSeen == int'(!stopVal), req, "stop error count", serrSeen, int'(!stopVal));
  endtask

  initial begin
    waitClks(3);
    // R1: reset state
    check(rxDone == 0 && parityErr == 0 && stopErr == 0, "R1", "strobes in reset",
          {rxDone, parityErr, stopErr}, 0);
    check(rxByte == 8'h00, "R1", "byte in reset", rxByte, 0);
    rstN = 1'b1;
    waitClks(4 * BIT_CLKS);
    check(doneSeen == 0, "R1", "idle line gives no frame", doneSeen, 0);

    frameCase(8'hA5, 2'b00, 2'b10, 0, 1, "R4");   // 8 bits, no parity
    frameCase(8'h3C, 2'b00, 2'b00, 0, 1, "R5");   // 8 bits even
    frameCase(8'hDA, 2'b01, 2'b00, 0, 1, "R4");   // 7 bits even
    frameCase(8'h2D, 2'b10, 2'b01, 0, 1, "R5");   // 6 bits odd
    frameCase(8'hFF, 2'b11, 2'b00, 0, 1, "R4");   // 5 bits, upper cleared
    frameCase(8'h96, 2'b00, 2'b01, 1, 1, "R6");   // odd parity bit flipped
    frameCase(8'h13, 2'b11, 2'b00, 1, 1, "R6");   // even parity bit flipped
    frameCase(8'h81, 2'b00, 2'b10, 0, 0, "R7");   // low stop bit
    frameCase(8'h5E, 2'b00, 2'b10, 0, 1, "R7");   // recovery after stop error
    frameCase(8'h07, 2'b01, 2'b01, 1, 0, "R9");   // both errors in one frame

    // R2: glitch shorter than half a bit is rejected
    clearCounts();
    driveBit(1'b0, 4 * TICK_DIV);
    driveBit(1'b1, 3 * BIT_CLKS);
    check(doneSeen == 0, "R2", "glitch rejected", doneSeen, 0);
    frameCase(8'h6B, 2'b00, 2'b10, 0, 1, "R2");

    // R3: full FIFO refuses a start
    wordSel = 2'b00; parSel = 2'b10;
    fifoFull = 1'b1; clearCounts();
    sendFrame(8'h00, 8, 2, 0, 1);
    check(doneSeen == 0, "R3", "no frame while FIFO full", doneSeen, 0);
    fifoFull = 1'b0;
    // R3: halted receiver refuses a start
    rxHold = 1'b1; clearCounts();
    sendFrame(8'h00, 8, 2, 0, 1);
    check(doneSeen == 0, "R3", "no frame while halted", doneSeen, 0);
    rxHold = 1'b0;
    frameCase(8'hC3, 2'b00, 2'b10, 0, 1, "R3");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    waitClks(150000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule